// File: doc/BRIEF.md
# Double-Buffered Color Matrix Transform

This block converts a stream of RGB pixels into R'G'B' by multiplying each pixel by a 3x4 matrix. Each output channel is the weighted sum of the three input channels plus a constant offset term. It is then rounded and limited to the legal pixel range. Coefficients are signed fixed point with 13 fraction bits (1.0 is 8192). Pixels are unsigned 12-bit values.

The block holds two complete coefficient banks. A host reads which bank is live and loads the other one. It then writes a mode value that names the freshly loaded bank. That mode value is only staged when written. It becomes live at the next frame-start pulse, so a frame never mixes two matrices.

A mode of 0 selects bypass. The live mode can be read back through an index/data pair on the register interface. The datapath is a two-stage pipeline (products, then sum with rounding and clamping), and the valid flag travels with the data.

Top module: `color_matrix_xform`

## Requirements
- R1: After reset, out_valid is 0, pix_out is 0, dbg_data is 0, both banks hold all-zero coefficients, and the staged and live modes are both 0.
- R2: A write to reg_addr {bank, pair} loads one coefficient pair. Bank is reg_addr[3], where 0 is the primary bank and 1 the alternate bank. Pair is reg_addr[2:0], from 0 to 5. The coefficients are numbered row-major as k = 4*row + col, with rows R', G', B' and columns R, G, B, offset. Pair p holds coefficient 2p in reg_wdata[15:0] and coefficient 2p+1 in reg_wdata[31:16].
- R3: For each output row, the value before clamping is floor((cR*R + cG*G + cB*B + cOff*4096 + 4096) / 8192). A value exactly half-way between two integers rounds up.
- R4: A result below 0 is output as 0, and a result above 4095 is output as 4095.
- R5: A pixel is presented with pix_valid high and sampled at a rising edge. Its result and out_valid=1 appear after the following rising edge. out_valid is 0 in every cycle that has no corresponding input pixel.
- R6: With the live mode at 0 (bypass), pix_out equals pix_in with the same latency as in R5. pix_in and pix_out are packed as {R[35:24], G[23:12], B[11:0]}.
- R7: A write to reg_addr 14 only stages a mode, taken from reg_wdata[2:0]. The staged mode becomes live at the rising edge that samples frame_start high. A pixel sampled at that same edge is still processed with the previous mode.
- R8: A mode write whose value is not 0, 4 or 5 is ignored, and the staged mode keeps its value.
- R9: A write to reg_addr 15 sets a 4-bit readback index from reg_wdata[3:0]. dbg_data returns the live mode when that index is 9, and returns 0 for any other index.
- R10: Live mode 4 uses the primary bank and live mode 5 uses the alternate bank. Loading the bank that is not live leaves the output of the live bank unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (coefficient pairs, mode at 14, readback index at 15) |
| reg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Frame boundary pulse; makes the staged mode live |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_in | input | 36 | Input pixel {R,G,B}, 12 bits each |
| out_valid | output | 1 | Output pixel qualifier |
| pix_out | output | 36 | Output pixel {R',G',B'}, 12 bits each |
| dbg_data | output | 32 | Readback data for the current index |

## Verification
A pixel driven before rising edge E is due on pix_out, with out_valid high, after edge E+1. The bench drives on falling edges and compares two falling edges after the drive. In the random stream it keeps a two-deep queue of expected values, so that each cycle's output is compared with the pixel sent two cycles earlier. A register write, and the mode change a frame_start pulse causes, are visible at the falling edge that follows the latching edge. dbg_data is therefore read there, and a pixel that shares its cycle with frame_start is expected to carry the old matrix.

// File: rtl/cmx_pkg.sv
`timescale 1ns/1ps
package cmx_pkg;
  localparam int PIX_W  = 12;
  localparam int COEF_W = 16;
  localparam int FRAC   = 13;
  localparam int NCH    = 3;
  localparam int NCOL   = 4;
  localparam int NCOEF  = NCH * NCOL;
  localparam int NPAIR  = NCOEF / 2;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 2 * COEF_W;
  localparam int IDX_W  = 4;
  localparam int PROD_W = COEF_W + PIX_W + 1;
  localparam int SUM_W  = PROD_W + 2;
  localparam int PIXV_W = NCH * PIX_W;

  localparam logic [ADDR_W-1:0] ADDR_MODE   = ADDR_W'(14);
  localparam logic [ADDR_W-1:0] ADDR_DBGIDX = ADDR_W'(15);
  localparam logic [IDX_W-1:0]  DBG_MODE_IX = IDX_W'(9);

  localparam logic signed [SUM_W-1:0] RND_HALF = SUM_W'(1) <<< (FRAC - 1);
  localparam logic signed [SUM_W-1:0] PIX_MAX  = SUM_W'((1 << PIX_W) - 1);

  typedef logic [NCOEF-1:0][COEF_W-1:0] bank_t;
  typedef logic [NCOEF-1:0][PROD_W-1:0] terms_t;

  typedef enum logic [2:0] {
    MODE_BYPASS = 3'd0,
    MODE_PRI    = 3'd4,
    MODE_ALT    = 3'd5
  } mode_e;

  function automatic logic mode_legal(logic [2:0] v);
    return (v == 3'd0) || (v == 3'd4) || (v == 3'd5);
  endfunction

  // channel 0 is R in the top field, channel NCH-1 is B in the bottom field
  function automatic logic [PIX_W-1:0] get_ch(logic [PIXV_W-1:0] p, int ch);
    return p[(NCH-1-ch)*PIX_W +: PIX_W];
  endfunction

  function automatic logic [PROD_W-1:0] scale_term(logic [COEF_W-1:0] c,
                                                   logic [PIX_W-1:0] p);
    logic signed [PROD_W-1:0] cx;
    logic signed [PROD_W-1:0] px;
    cx = PROD_W'($signed(c));
    px = PROD_W'({1'b0, p});
    return cx * px;
  endfunction

  function automatic logic [PROD_W-1:0] offset_term(logic [COEF_W-1:0] c);
    logic signed [PROD_W-1:0] cx;
    cx = PROD_W'($signed(c));
    return cx <<< PIX_W;
  endfunction

  function automatic logic signed [SUM_W-1:0] row_sum(terms_t t, int ch);
    logic signed [SUM_W-1:0] a;
    a = '0;
    for (int c = 0; c < NCOL; c++) a = a + SUM_W'($signed(t[ch*NCOL+c]));
    return a;
  endfunction

  function automatic logic [PIX_W-1:0] round_clamp(logic signed [SUM_W-1:0] s);
    logic signed [SUM_W-1:0] r;
    r = (s + RND_HALF) >>> FRAC;
    if (r < 0) return '0;
    else if (r > PIX_MAX) return '1;
    else return r[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/cmx_regs.sv
`timescale 1ns/1ps
module cmx_regs
  import cmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              frame_start,
  output bank_t             coef_live,
  output mode_e             mode_live,
  output logic [DATA_W-1:0] dbg_data
);
  logic [DATA_W-1:0] pair_q [2][NPAIR];
  logic [1:0][NPAIR-1:0] pair_hit;
  mode_e pend_q, act_q;
  logic [IDX_W-1:0] dbg_idx_q;
  logic mode_wr, mode_wr_ok, mode_load, idx_wr, use_alt;

  assign mode_wr    = reg_we && (reg_addr == ADDR_MODE);
  assign mode_wr_ok = mode_wr && mode_legal(reg_wdata[2:0]);
  assign mode_load  = frame_start;
  assign idx_wr     = reg_we && (reg_addr == ADDR_DBGIDX);
  assign use_alt    = (act_q == MODE_ALT);

  always_comb begin
    for (int b = 0; b < 2; b++)
      for (int p = 0; p < NPAIR; p++)
        pair_hit[b][p] = reg_we && (reg_addr == ADDR_W'(b*8 + p));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < NPAIR; p++) pair_q[b][p] <= '0;
    end else begin
      for (int b = 0; b < 2; b++)
        for (int p = 0; p < NPAIR; p++)
          if (pair_hit[b][p]) pair_q[b][p] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= MODE_BYPASS;
      act_q     <= MODE_BYPASS;
      dbg_idx_q <= '0;
    end else begin
      if (mode_wr_ok) pend_q <= mode_e'(reg_wdata[2:0]);
      if (mode_load)  act_q  <= pend_q;
      if (idx_wr)     dbg_idx_q <= reg_wdata[IDX_W-1:0];
    end
  end

  always_comb begin
    for (int p = 0; p < NPAIR; p++) begin
      coef_live[2*p]   = pair_q[use_alt][p][COEF_W-1:0];
      coef_live[2*p+1] = pair_q[use_alt][p][DATA_W-1:COEF_W];
    end
  end

  assign mode_live = act_q;
  assign dbg_data  = (dbg_idx_q == DBG_MODE_IX) ? DATA_W'(act_q) : '0;

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_load |=> $stable(act_q)); // R7
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> (act_q == $past(pend_q))); // R7
  AST_BAD_MODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && !mode_legal(reg_wdata[2:0])) |=> $stable(pend_q)); // R8
endmodule

// File: rtl/cmx_mult.sv
`timescale 1ns/1ps
module cmx_mult
  import cmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [PIXV_W-1:0] pix_in,
  input  bank_t             coef_live,
  input  mode_e             mode_live,
  output logic              s1_valid,
  output logic              s1_bypass,
  output logic [PIXV_W-1:0] s1_pix,
  output terms_t            s1_terms
);
  terms_t next_terms;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_row
    for (genvar col = 0; col < NCOL; col++) begin : g_col
      if (col < NCOL - 1) begin : g_scale
        assign next_terms[ch*NCOL+col] =
          scale_term(coef_live[ch*NCOL+col], get_ch(pix_in, col));
      end else begin : g_offset
        assign next_terms[ch*NCOL+col] = offset_term(coef_live[ch*NCOL+col]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_bypass <= 1'b0;
      s1_pix    <= '0;
      s1_terms  <= '0;
    end else begin
      s1_valid <= pix_valid;
      if (pix_valid) begin
        s1_bypass <= (mode_live == MODE_BYPASS);
        s1_pix    <= pix_in;
        s1_terms  <= next_terms;
      end
    end
  end

  AST_S1_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> s1_valid); // R5
endmodule

// File: rtl/cmx_sum.sv
`timescale 1ns/1ps
module cmx_sum
  import cmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s1_valid,
  input  logic              s1_bypass,
  input  logic [PIXV_W-1:0] s1_pix,
  input  terms_t            s1_terms,
  output logic              out_valid,
  output logic [PIXV_W-1:0] pix_out
);
  logic [PIXV_W-1:0] mat_res;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_row
    logic signed [SUM_W-1:0] acc;
    assign acc = row_sum(s1_terms, ch);
    assign mat_res[(NCH-1-ch)*PIX_W +: PIX_W] = round_clamp(acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      pix_out   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) pix_out <= s1_bypass ? s1_pix : mat_res;
    end
  end

  AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid); // R5
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid); // R5
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_valid && s1_bypass) |=> (pix_out == $past(s1_pix))); // R6
endmodule

// File: rtl/color_matrix_xform.sv
`timescale 1ns/1ps
module color_matrix_xform
  import cmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              frame_start,
  input  logic              pix_valid,
  input  logic [PIXV_W-1:0] pix_in,
  output logic              out_valid,
  output logic [PIXV_W-1:0] pix_out,
  output logic [DATA_W-1:0] dbg_data
);
  bank_t             coef_live;
  mode_e             mode_live;
  logic              s1_valid, s1_bypass;
  logic [PIXV_W-1:0] s1_pix;
  terms_t            s1_terms;

  cmx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .frame_start(frame_start),
    .coef_live(coef_live), .mode_live(mode_live), .dbg_data(dbg_data)
  );

  cmx_mult u_mult (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_in(pix_in),
    .coef_live(coef_live), .mode_live(mode_live),
    .s1_valid(s1_valid), .s1_bypass(s1_bypass), .s1_pix(s1_pix),
    .s1_terms(s1_terms)
  );

  cmx_sum u_sum (
    .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_bypass(s1_bypass),
    .s1_pix(s1_pix), .s1_terms(s1_terms),
    .out_valid(out_valid), .pix_out(pix_out)
  );

  AST_LIVE_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_legal(mode_live)); // R8
endmodule

// File: tb/color_matrix_xform_bench.sv
`timescale 1ns/1ps
module color_matrix_xform_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        frame_start = 1'b0;
  logic        pix_valid = 1'b0;
  logic [35:0] pix_in = '0;
  logic        out_valid;
  logic [35:0] pix_out;
  logic [31:0] dbg_data;

  color_matrix_xform u_color_matrix_xform (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .frame_start(frame_start), .pix_valid(pix_valid),
    .pix_in(pix_in), .out_valid(out_valid), .pix_out(pix_out),
    .dbg_data(dbg_data)
  );

  always #2.5 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic signed [15:0] bm [2][12];
  logic signed [15:0] stage [12];
  int m_pend = 0;
  int m_act  = 0;

  function automatic int ch_calc(int bk, int row, int r, int g, int b);
    longint t, t2, q;
    t = longint'(bm[bk][row*4]) * r + longint'(bm[bk][row*4+1]) * g
      + longint'(bm[bk][row*4+2]) * b + longint'(bm[bk][row*4+3]) * 4096;
    t2 = 2 * t + 8192;
    if (t2 >= 0) q = t2 / 16384;
    else         q = -((-t2 + 16383) / 16384);
    if (q < 0) q = 0;
    if (q > 4095) q = 4095;
    return int'(q);
  endfunction

  function automatic logic [35:0] expect_pix(int mode, int r, int g, int b);
    int bk;
    if (mode == 0) return {12'(r), 12'(g), 12'(b)};
    bk = (mode == 5) ? 1 : 0;
    return {12'(ch_calc(bk, 0, r, g, b)), 12'(ch_calc(bk, 1, r, g, b)),
            12'(ch_calc(bk, 2, r, g, b))};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_reg(int a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 14) begin
      if (d[2:0] == 3'd0 || d[2:0] == 3'd4 || d[2:0] == 3'd5) m_pend = int'(d[2:0]);
    end else if (a < 14 && a[2:0] < 6) begin
      bm[a[3]][2*a[2:0]]   = d[15:0];
      bm[a[3]][2*a[2:0]+1] = d[31:16];
    end
  endtask

  task automatic load_bank(int bk);
    for (int p = 0; p < 6; p++) write_reg(bk*8 + p, {stage[2*p+1], stage[2*p]});
  endtask

  task automatic clear_stage();
    for (int k = 0; k < 12; k++) stage[k] = '0;
  endtask

  task automatic frame();
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    m_act = m_pend;
  endtask

  task automatic one_pixel(string req, int r, int g, int b);
    logic [35:0] e;
    e = expect_pix(m_act, r, g, b);
    pix_valid = 1'b1; pix_in = {12'(r), 12'(g), 12'(b)};
    @(negedge clk);
    pix_valid = 1'b0;
    @(negedge clk);
    chk({req, " valid"}, 64'(out_valid), 64'd1);
    chk(req, 64'(pix_out), 64'(e));
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [35:0] e_old;
    logic [35:0] d1, d2;
    bit v1, v2, nv;
    int r, g, b;
    for (int bk = 0; bk < 2; bk++) for (int k = 0; k < 12; k++) bm[bk][k] = '0;
    void'($urandom(32'h5EED_C0DE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 pix_out", 64'(pix_out), 64'd0);
    chk("R1 dbg_data", 64'(dbg_data), 64'd0);
    write_reg(15, 32'd9);
    chk("R1 live mode", 64'(dbg_data), 64'd0);

    // R6 bypass
    one_pixel("R6 bypass", 123, 4095, 0);

    // primary bank: R'=0.5R, G'=G+0.5 offset, B'=-B
    clear_stage();
    stage[0] = 16'sd4096; stage[5] = 16'sd8192; stage[7] = 16'sd4096;
    stage[10] = -16'sd8192;
    load_bank(0);
    write_reg(14, 32'd4);
    chk("R7 staged only", 64'(dbg_data), 64'd0);
    one_pixel("R7 still bypass", 3, 100, 500);
    frame();
    chk("R9 live mode 4", 64'(dbg_data), 64'd4);
    one_pixel("R3 rounding", 3, 100, 500);
    one_pixel("R4 clamp", 1, 4095, 7);

    // alternate bank: channel rotate R'=G, G'=B, B'=R
    clear_stage();
    stage[1] = 16'sd8192; stage[6] = 16'sd8192; stage[8] = 16'sd8192;
    load_bank(1);
    write_reg(14, 32'd5);
    one_pixel("R10 live bank unaffected", 10, 20, 30);
    chk("R10 mode still 4", 64'(dbg_data), 64'd4);

    // pixel in the same cycle as frame_start keeps the old matrix
    e_old = expect_pix(m_act, 10, 20, 30);
    pix_valid = 1'b1; frame_start = 1'b1; pix_in = {12'd10, 12'd20, 12'd30};
    @(negedge clk);
    pix_valid = 1'b0; frame_start = 1'b0; m_act = m_pend;
    @(negedge clk);
    chk("R7 coincident pixel", 64'(pix_out), 64'(e_old));
    one_pixel("R2 pair layout rotate", 10, 20, 30);
    chk("R9 live mode 5", 64'(dbg_data), 64'd5);

    // R8 illegal modes ignored
    write_reg(14, 32'd6);
    write_reg(14, 32'd3);
    frame();
    chk("R8 mode kept", 64'(dbg_data), 64'd5);
    one_pixel("R8 matrix kept", 7, 8, 9);

    // R9 other index
    write_reg(15, 32'd3);
    chk("R9 other index", 64'(dbg_data), 64'd0);
    write_reg(15, 32'd9);
    chk("R9 index back", 64'(dbg_data), 64'd5);

    // R4 saturation at top
    clear_stage();
    stage[0] = 16'sh7FFF; stage[1] = 16'sh7FFF; stage[2] = 16'sh7FFF;
    stage[5] = 16'sd8192; stage[10] = 16'sd8192;
    load_bank(0);
    write_reg(14, 32'd4);
    frame();
    one_pixel("R4 saturate", 4095, 4095, 4095);

    // R5 latency of a lone pixel
    e_old = expect_pix(m_act, 100, 200, 300);
    pix_valid = 1'b1; pix_in = {12'd100, 12'd200, 12'd300};
    @(negedge clk);
    pix_valid = 1'b0;
    chk("R5 not early", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk("R5 due", 64'(out_valid), 64'd1);
    chk("R5 data", 64'(pix_out), 64'(e_old));
    @(negedge clk);
    chk("R5 single", 64'(out_valid), 64'd0);

    // random stream through the alternate bank
    for (int k = 0; k < 12; k++) stage[k] = 16'($signed($urandom_range(24576, 0)) - 12288);
    load_bank(1);
    write_reg(14, 32'd5);
    frame();
    v1 = 1'b0; v2 = 1'b0; d1 = '0; d2 = '0;
    for (int i = 0; i < 402; i++) begin
      chk("R5 stream valid", 64'(out_valid), 64'(v2));
      if (v2) chk("R3 stream data", 64'(pix_out), 64'(d2));
      v2 = v1; d2 = d1;
      nv = (i < 400) && ($urandom_range(3, 0) != 0);
      r = ($urandom_range(7, 0) == 0) ? 4095 : int'($urandom_range(4095, 0));
      g = ($urandom_range(7, 0) == 0) ? 0    : int'($urandom_range(4095, 0));
      b = int'($urandom_range(4095, 0));
      v1 = nv;
      if (nv) d1 = expect_pix(m_act, r, g, b);
      pix_valid = nv; pix_in = {12'(r), 12'(g), 12'(b)};
      @(negedge clk);
    end
    pix_valid = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule